// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block predicts where an indirect branch will jump. It holds a set-associative cache of branch targets. A lookup presents a branch address, a thread number and that thread's recent indirect targets, and one cycle later it returns a hit flag and a predicted destination. When the branch resolves, an update writes the real destination into the cache. If a way in the indexed set already holds the branch's tag, that way is overwritten. Otherwise an empty way is filled, and when the set is full a pseudo-random way is replaced.

The set index is an XOR hash of three things. The first is the instruction-aligned branch address. The second is a per-thread global direction history, which the block keeps itself. The third is up to a parameterised number of recent indirect targets. Each older target is shifted right by a further step before it is folded in, so its age affects the index. The caller supplies the targets with each request, youngest first. For an update it supplies only the targets older than the updating branch.

The block also maintains the direction history of every thread. Each predicted conditional branch shifts its outcome into the history and hands back the previous value as a checkpoint. A direction misprediction rebuilds the history from that checkpoint and the real outcome. A squash restores the checkpoint unchanged.

Lookups use a valid/ready handshake with back-pressure on the result. A request is taken only when `lk_ready` is high, which is when no result is pending or the pending result is being accepted in the same cycle. A result stays stable until `res_ready` is seen high. Updates are never stalled, and `upd_ready` is tied high.

Top module: `itgt_top`

## Requirements
- R1: After reset every way is invalid, every thread's history is zero, `res_valid` is low and `lk_ready` is high.
- R2: The set index is the low log2(SETS) bits of (PC >> SHIFT) XOR history XOR the path contribution. SETS and WAYS must be powers of two. The defaults are SHIFT=2, SETS=16, WAYS=4, TAG_W=8, PATH_LEN=2 and GHR_W=8.
- R3: Path entry p sits in bits [p*PC_W +: PC_W] and entry 0 is the youngest. Entry p is folded in only when p < count. It is shifted right by SHIFT + p*STEP, where STEP = log2(SETS)/PATH_LEN (2 by default).
- R4: The tag is bits [TAG_W-1:0] of PC >> SHIFT. Addresses that differ only above those bits and above the index bits alias to the same entry.
- R5: An accepted lookup yields `res_valid` on the next cycle. `res_hit` is set when a valid way of the indexed set holds the tag, and `res_target` then gives that way's target.
- R6: An update whose tag is already present overwrites that way's target. No second copy of the tag is allocated.
- R7: An update that misses fills the lowest-numbered invalid way of the set, if one exists.
- R8: An update that misses in a full set replaces one way chosen by a free-running LFSR. The other ways stay intact.
- R9: A direction prediction drives `dir_ckpt` with the thread's current history. On the next edge the history becomes {history[GHR_W-2:0], taken}.
- R10: A repair sets the thread's history to {checkpoint[GHR_W-2:0], actual outcome}.
- R11: A squash restores the thread's history to the checkpoint. For the same thread in one cycle, squash wins over repair, and repair wins over prediction.
- R12: While `res_valid` is high and `res_ready` is low, `lk_ready` is low and the result holds stable.
- R13: A lookup sees the cache contents and the history as they stood before any update or direction event in the same cycle.
- R14: Each thread's history is independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_pc | input | PC_W | Branch address to predict |
| lk_tid | input | TID_W | Thread of the lookup |
| lk_path_tgt | input | PATH_LEN*PC_W | Recent indirect targets, entry 0 youngest |
| lk_path_cnt | input | CNT_W | Number of valid path entries |
| res_valid | output | 1 | Prediction valid |
| res_ready | input | 1 | Consumer takes the prediction |
| res_hit | output | 1 | Tag matched |
| res_target | output | PC_W | Predicted target |
| upd_valid | input | 1 | Update valid |
| upd_ready | output | 1 | Always high |
| upd_pc | input | PC_W | Resolved branch address |
| upd_tid | input | TID_W | Thread of the update |
| upd_target | input | PC_W | Resolved target |
| upd_path_tgt | input | PATH_LEN*PC_W | Targets older than this branch, entry 0 youngest |
| upd_path_cnt | input | CNT_W | Number of valid path entries |
| dir_valid | input | 1 | Conditional direction predicted |
| dir_tid | input | TID_W | Thread of the prediction (also selects `dir_ckpt`) |
| dir_taken | input | 1 | Predicted outcome |
| dir_ckpt | output | GHR_W | Current history of thread `dir_tid` |
| fix_valid | input | 1 | Direction misprediction repair |
| fix_tid | input | TID_W | Thread to repair |
| fix_ckpt | input | GHR_W | Checkpoint taken at prediction |
| fix_taken | input | 1 | Actual outcome |
| sq_valid | input | 1 | Squash restore |
| sq_tid | input | TID_W | Thread to restore |
| sq_ckpt | input | GHR_W | Checkpoint to restore |

## Verification
A lookup and an update can land in the same cycle on the same set and the same tag. A lookup and a direction prediction can also share a cycle, and both of them feed the index. The bench raises `lk_valid` and `upd_valid` together for a branch that already has a stored target. It expects the old target in that cycle's result and the new one on the next lookup. It also raises `lk_valid` and `dir_valid` together, and expects a hit under the history value from before the shift. A separate check drives squash, repair and prediction into one thread in one cycle and judges the priority by the history read back on `dir_ckpt`.

// File: rtl/itgt_pkg.sv
package itgt_pkg;

  typedef enum logic [1:0] {
    SRC_HIT  = 2'd0,
    SRC_FREE = 2'd1,
    SRC_RAND = 2'd2
  } way_src_e;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

endpackage

// File: rtl/itgt_hash.sv
module itgt_hash #(
  parameter int PC_W      = 32,
  parameter int SHIFT     = 2,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 8,
  parameter int PATH_LEN  = 2,
  parameter int GHR_W     = 8,
  parameter int CNT_W     = 2,
  parameter bit HASH_GHR  = 1'b1,
  parameter bit HASH_PATH = 1'b1
) (
  input  logic [PC_W-1:0]          pc,
  input  logic [GHR_W-1:0]         ghr,
  input  logic [PATH_LEN*PC_W-1:0] path_tgt,
  input  logic [CNT_W-1:0]         path_cnt,
  output logic [IDX_W-1:0]         idx,
  output logic [TAG_W-1:0]         tag
);

  localparam int STEP = IDX_W / PATH_LEN;

  logic [PC_W-1:0] aligned;
  logic [PC_W-1:0] contrib [PATH_LEN];
  logic [PC_W-1:0] acc;

  assign aligned = pc >> SHIFT;

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
    if (HASH_PATH) begin : g_on
      assign contrib[p] = (path_cnt > CNT_W'(p))
                        ? (path_tgt[p*PC_W +: PC_W] >> (SHIFT + p*STEP))
                        : '0;
    end else begin : g_off
      assign contrib[p] = '0;
    end
  end

  always_comb begin
    acc = aligned;
    if (HASH_GHR) acc = acc ^ PC_W'(ghr);
    for (int p = 0; p < PATH_LEN; p++) acc = acc ^ contrib[p];
  end

  assign idx = acc[IDX_W-1:0];
  assign tag = aligned[TAG_W-1:0];

endmodule

// File: rtl/itgt_hist.sv
module itgt_hist #(
  parameter int THREADS = 2,
  parameter int GHR_W   = 8,
  parameter int TID_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] lk_tid,
  output logic [GHR_W-1:0] lk_ghr,
  input  logic [TID_W-1:0] upd_tid,
  output logic [GHR_W-1:0] upd_ghr,
  input  logic             dir_valid,
  input  logic [TID_W-1:0] dir_tid,
  input  logic             dir_taken,
  output logic [GHR_W-1:0] dir_ckpt,
  input  logic             fix_valid,
  input  logic [TID_W-1:0] fix_tid,
  input  logic [GHR_W-1:0] fix_ckpt,
  input  logic             fix_taken,
  input  logic             sq_valid,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [GHR_W-1:0] sq_ckpt
);

  logic [GHR_W-1:0] ghr [THREADS];

  assign lk_ghr   = ghr[lk_tid];
  assign upd_ghr  = ghr[upd_tid];
  assign dir_ckpt = ghr[dir_tid];

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic sq_hit, fix_hit, dir_hit;
    assign sq_hit  = sq_valid  && (sq_tid  == TID_W'(t));
    assign fix_hit = fix_valid && (fix_tid == TID_W'(t));
    assign dir_hit = dir_valid && (dir_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n)        ghr[t] <= '0;
      else if (sq_hit)   ghr[t] <= sq_ckpt;
      else if (fix_hit)  ghr[t] <= {fix_ckpt[GHR_W-2:0], fix_taken};
      else if (dir_hit)  ghr[t] <= {ghr[t][GHR_W-2:0], dir_taken};
    end
  end

  assert_squash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> ghr[$past(sq_tid)] == $past(sq_ckpt));

  assert_repair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_valid && !(sq_valid && sq_tid == fix_tid))
    |=> ghr[$past(fix_tid)] == {$past(fix_ckpt[GHR_W-2:0]), $past(fix_taken)});

  assert_predict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !(sq_valid && sq_tid == dir_tid) && !(fix_valid && fix_tid == dir_tid))
    |=> ghr[$past(dir_tid)] == {$past(dir_ckpt[GHR_W-2:0]), $past(dir_taken)});

endmodule

// File: rtl/itgt_store.sv
module itgt_store
  import itgt_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic [PC_W-1:0]  res_target,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [PC_W-1:0]  upd_target
);

  logic [WAYS-1:0]  vld  [SETS];
  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [PC_W-1:0]  tgts [SETS][WAYS];

  logic [15:0]      lfsr;
  logic [WAYS-1:0]  lk_match;
  logic [PC_W-1:0]  lk_sel;
  logic             lk_fire;
  logic             up_hit, free_any;
  logic [WAY_W-1:0] hit_way, free_way, wr_way;
  way_src_e         src;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= lfsr_step(lfsr);
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld[lk_idx][w] && (tags[lk_idx][w] == lk_tag);
  end

  always_comb begin
    lk_sel = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_match[w]) lk_sel = lk_sel | tgts[lk_idx][w];
  end

  assign lk_ready = !res_valid || res_ready;
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_target <= '0;
    end else if (lk_fire) begin
      res_valid  <= 1'b1;
      res_hit    <= |lk_match;
      res_target <= lk_sel;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  always_comb begin
    up_hit   = 1'b0;
    hit_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld[upd_idx][w] && tags[upd_idx][w] == upd_tag) begin
        up_hit  = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!vld[upd_idx][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    if (up_hit)        src = SRC_HIT;
    else if (free_any) src = SRC_FREE;
    else               src = SRC_RAND;
    case (src)
      SRC_HIT:  wr_way = hit_way;
      SRC_FREE: wr_way = free_way;
      default:  wr_way = lfsr[WAY_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (upd_valid) begin
      tags[upd_idx][wr_way] <= upd_tag;
      tgts[upd_idx][wr_way] <= upd_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (upd_valid) begin
      vld[upd_idx][wr_way] <= 1'b1;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_target)));

  assert_single_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_fill_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !up_hit && free_any)
    |=> $countones(vld[$past(upd_idx)]) == $countones($past(vld[upd_idx])) + 1);

  assert_full_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !free_any) |=> (vld[$past(upd_idx)] == {WAYS{1'b1}}));

endmodule

// File: rtl/itgt_top.sv
module itgt_top #(
  parameter int PC_W      = 32,
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int TAG_W     = 8,
  parameter int PATH_LEN  = 2,
  parameter int SHIFT     = 2,
  parameter int THREADS   = 2,
  parameter int GHR_W     = 8,
  parameter bit HASH_GHR  = 1'b1,
  parameter bit HASH_PATH = 1'b1,
  localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W    = $clog2(PATH_LEN + 1),
  localparam int IDX_W    = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  output logic                     lk_ready,
  input  logic [PC_W-1:0]          lk_pc,
  input  logic [TID_W-1:0]         lk_tid,
  input  logic [PATH_LEN*PC_W-1:0] lk_path_tgt,
  input  logic [CNT_W-1:0]         lk_path_cnt,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic                     res_hit,
  output logic [PC_W-1:0]          res_target,
  input  logic                     upd_valid,
  output logic                     upd_ready,
  input  logic [PC_W-1:0]          upd_pc,
  input  logic [TID_W-1:0]         upd_tid,
  input  logic [PC_W-1:0]          upd_target,
  input  logic [PATH_LEN*PC_W-1:0] upd_path_tgt,
  input  logic [CNT_W-1:0]         upd_path_cnt,
  input  logic                     dir_valid,
  input  logic [TID_W-1:0]         dir_tid,
  input  logic                     dir_taken,
  output logic [GHR_W-1:0]         dir_ckpt,
  input  logic                     fix_valid,
  input  logic [TID_W-1:0]         fix_tid,
  input  logic [GHR_W-1:0]         fix_ckpt,
  input  logic                     fix_taken,
  input  logic                     sq_valid,
  input  logic [TID_W-1:0]         sq_tid,
  input  logic [GHR_W-1:0]         sq_ckpt
);

  logic [GHR_W-1:0] lk_ghr, upd_ghr;
  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, upd_tag;

  assign upd_ready = 1'b1;

  itgt_hist #(.THREADS(THREADS), .GHR_W(GHR_W), .TID_W(TID_W)) u_hist (
    .clk, .rst_n,
    .lk_tid, .lk_ghr, .upd_tid, .upd_ghr,
    .dir_valid, .dir_tid, .dir_taken, .dir_ckpt,
    .fix_valid, .fix_tid, .fix_ckpt, .fix_taken,
    .sq_valid, .sq_tid, .sq_ckpt
  );

  itgt_hash #(.PC_W(PC_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W),
              .PATH_LEN(PATH_LEN), .GHR_W(GHR_W), .CNT_W(CNT_W),
              .HASH_GHR(HASH_GHR), .HASH_PATH(HASH_PATH)) u_hash_lk (
    .pc(lk_pc), .ghr(lk_ghr), .path_tgt(lk_path_tgt), .path_cnt(lk_path_cnt),
    .idx(lk_idx), .tag(lk_tag)
  );

  itgt_hash #(.PC_W(PC_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W),
              .PATH_LEN(PATH_LEN), .GHR_W(GHR_W), .CNT_W(CNT_W),
              .HASH_GHR(HASH_GHR), .HASH_PATH(HASH_PATH)) u_hash_upd (
    .pc(upd_pc), .ghr(upd_ghr), .path_tgt(upd_path_tgt), .path_cnt(upd_path_cnt),
    .idx(upd_idx), .tag(upd_tag)
  );

  itgt_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PC_W(PC_W),
               .IDX_W(IDX_W), .WAY_W(WAY_W)) u_store (
    .clk, .rst_n,
    .lk_valid, .lk_ready, .lk_idx, .lk_tag,
    .res_valid, .res_ready, .res_hit, .res_target,
    .upd_valid, .upd_idx, .upd_tag, .upd_target
  );

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

endmodule

// File: tb/test_itgt_top.sv
module test_itgt_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_ready;
  logic [31:0] lk_pc = 0;
  logic [0:0] lk_tid = 0;
  logic [63:0] lk_path_tgt = 0;
  logic [1:0] lk_path_cnt = 0;
  logic res_valid, res_ready = 1, res_hit;
  logic [31:0] res_target;
  logic upd_valid = 0, upd_ready;
  logic [31:0] upd_pc = 0, upd_target = 0;
  logic [0:0] upd_tid = 0;
  logic [63:0] upd_path_tgt = 0;
  logic [1:0] upd_path_cnt = 0;
  logic dir_valid = 0, dir_taken = 0;
  logic [0:0] dir_tid = 0;
  logic [7:0] dir_ckpt;
  logic fix_valid = 0, fix_taken = 0;
  logic [0:0] fix_tid = 0;
  logic [7:0] fix_ckpt = 0;
  logic sq_valid = 0;
  logic [0:0] sq_tid = 0;
  logic [7:0] sq_ckpt = 0;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itgt_top i_itgt_top (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [0:0] tid, input logic [31:0] tgt,
                           input logic [63:0] path, input logic [1:0] cnt);
    upd_valid = 1; upd_pc = pc; upd_tid = tid; upd_target = tgt;
    upd_path_tgt = path; upd_path_cnt = cnt;
    tick();
    upd_valid = 0;
  endtask

  task automatic do_lookup(input logic [31:0] pc, input logic [0:0] tid, input logic [63:0] path,
                           input logic [1:0] cnt, output logic hit, output logic [31:0] tgt);
    lk_valid = 1; lk_pc = pc; lk_tid = tid; lk_path_tgt = path; lk_path_cnt = cnt;
    tick();
    lk_valid = 0;
    hit = res_hit;
    tgt = res_target;
    check(res_valid == 1'b1, "R5 result valid", res_valid, 1);
  endtask

  function automatic logic [7:0] peek_ghr(input logic [0:0] tid);
    dir_tid = tid;
    return 8'h00;
  endfunction

  task automatic read_ghr(input logic [0:0] tid, output logic [7:0] g);
    dir_tid = tid;
    #1;
    g = dir_ckpt;
  endtask

  task automatic do_dir(input logic [0:0] tid, input logic taken, output logic [7:0] ck);
    dir_valid = 1; dir_tid = tid; dir_taken = taken;
    #1;
    ck = dir_ckpt;
    tick();
    dir_valid = 0;
  endtask

  task automatic do_squash(input logic [0:0] tid, input logic [7:0] ck);
    sq_valid = 1; sq_tid = tid; sq_ckpt = ck;
    tick();
    sq_valid = 0;
  endtask

  task automatic t_reset();
    logic h; logic [31:0] t; logic [7:0] g;
    check(res_valid == 0, "R1 res_valid low", res_valid, 0);
    check(lk_ready == 1, "R1 lk_ready high", lk_ready, 1);
    check(upd_ready == 1, "R1 upd_ready high", upd_ready, 1);
    read_ghr(0, g); check(g == 0, "R1 history t0 zero", g, 0);
    read_ghr(1, g); check(g == 0, "R1 history t1 zero", g, 0);
    do_lookup(32'h100, 0, 0, 0, h, t);
    check(h == 0, "R1 empty cache misses", h, 0);
  endtask

  task automatic t_hit_miss();
    logic h; logic [31:0] t;
    do_update(32'h1000, 0, 32'hAAAA0000, 0, 0);
    do_lookup(32'h1000, 0, 0, 0, h, t);
    check(h == 1, "R5 hit after update", h, 1);
    check(t == 32'hAAAA0000, "R5 target", t, 32'hAAAA0000);
    do_lookup(32'h1400, 0, 0, 0, h, t);
    check(h == 1 && t == 32'hAAAA0000, "R4 tag truncation alias", {h, t}, {1'b1, 32'hAAAA0000});
    do_lookup(32'h1040, 0, 0, 0, h, t);
    check(h == 0, "R4 different tag misses", h, 0);
  endtask

  task automatic t_fill();
    logic h; logic [31:0] t;
    do_update(32'h1000, 0, 32'hBBBB0000, 0, 0);
    do_update(32'h1040, 0, 32'h11110000, 0, 0);
    do_update(32'h1080, 0, 32'h22220000, 0, 0);
    do_update(32'h10C0, 0, 32'h33330000, 0, 0);
    do_lookup(32'h1000, 0, 0, 0, h, t);
    check(h && t == 32'hBBBB0000, "R6 overwrite in place", t, 32'hBBBB0000);
    do_lookup(32'h1040, 0, 0, 0, h, t);
    check(h && t == 32'h11110000, "R7 fill way", t, 32'h11110000);
    do_lookup(32'h1080, 0, 0, 0, h, t);
    check(h && t == 32'h22220000, "R7 fill way", t, 32'h22220000);
    do_lookup(32'h10C0, 0, 0, 0, h, t);
    check(h && t == 32'h33330000, "R7 fill way", t, 32'h33330000);
  endtask

  task automatic t_replace();
    logic h; logic [31:0] t; int hits;
    logic [31:0] pcs [5] = '{32'h1000, 32'h1040, 32'h1080, 32'h10C0, 32'h1100};
    do_update(32'h1100, 0, 32'h44440000, 0, 0);
    do_lookup(32'h1100, 0, 0, 0, h, t);
    check(h && t == 32'h44440000, "R8 new entry present", t, 32'h44440000);
    hits = 0;
    for (int i = 0; i < 5; i++) begin
      do_lookup(pcs[i], 0, 0, 0, h, t);
      if (h) hits++;
    end
    check(hits == 4, "R8 exactly one way replaced", hits, 4);
  endtask

  task automatic t_history();
    logic h; logic [31:0] t; logic [7:0] ck, g;
    do_update(32'h2004, 0, 32'h55550000, 0, 0);
    do_dir(0, 1, ck);
    check(ck == 8'h00, "R9 checkpoint prior value", ck, 0);
    do_lookup(32'h2004, 0, 0, 0, h, t);
    check(h == 0, "R2 history changes index", h, 0);
    do_dir(0, 1, ck);
    check(ck == 8'h01, "R9 history shifted", ck, 1);
    fix_valid = 1; fix_tid = 0; fix_ckpt = 8'h01; fix_taken = 0;
    tick(); fix_valid = 0;
    read_ghr(0, g);
    check(g == 8'h02, "R10 repair", g, 8'h02);
    do_squash(0, 8'h00);
    read_ghr(0, g);
    check(g == 8'h00, "R11 squash restore", g, 0);
    do_lookup(32'h2004, 0, 0, 0, h, t);
    check(h && t == 32'h55550000, "R11 hit after restore", t, 32'h55550000);
    sq_valid = 1; sq_tid = 0; sq_ckpt = 8'h05;
    fix_valid = 1; fix_tid = 0; fix_ckpt = 8'h01; fix_taken = 1;
    dir_valid = 1; dir_tid = 0; dir_taken = 1;
    tick(); sq_valid = 0;
    dir_valid = 0;
    read_ghr(0, g);
    check(g == 8'h05, "R11 squash wins", g, 8'h05);
    fix_ckpt = 8'h03; fix_taken = 0;
    dir_valid = 1; dir_tid = 0; dir_taken = 1;
    tick(); fix_valid = 0; dir_valid = 0;
    read_ghr(0, g);
    check(g == 8'h06, "R11 repair wins over prediction", g, 8'h06);
    do_squash(0, 8'h00);
  endtask

  task automatic t_threads();
    logic h; logic [31:0] t; logic [7:0] ck, g;
    do_dir(1, 1, ck);
    read_ghr(0, g);
    check(g == 8'h00, "R14 thread0 untouched", g, 0);
    read_ghr(1, g);
    check(g == 8'h01, "R14 thread1 shifted", g, 1);
    do_lookup(32'h2004, 1, 0, 0, h, t);
    check(h == 0, "R14 thread1 index differs", h, 0);
    do_lookup(32'h2004, 0, 0, 0, h, t);
    check(h == 1, "R14 thread0 still hits", h, 1);
    do_squash(1, 8'h00);
  endtask

  task automatic t_path();
    logic h; logic [31:0] t;
    do_update(32'h3008, 0, 32'h66660000, {32'h0, 32'h10}, 2'd1);
    do_lookup(32'h3008, 0, 0, 0, h, t);
    check(h == 0, "R3 path changes index", h, 0);
    do_lookup(32'h3008, 0, {32'h0, 32'h10}, 2'd1, h, t);
    check(h && t == 32'h66660000, "R3 same path hits", t, 32'h66660000);
    do_lookup(32'h3008, 0, {32'h0, 32'hFFFF0010}, 2'd1, h, t);
    check(h == 1, "R2 index masked", h, 1);
    do_update(32'h300C, 0, 32'h77770000, {32'h50, 32'h0}, 2'd2);
    do_lookup(32'h300C, 0, {32'h0, 32'h14}, 2'd1, h, t);
    check(h && t == 32'h77770000, "R3 older entry extra shift", t, 32'h77770000);
    do_lookup(32'h300C, 0, {32'h50, 32'h0}, 2'd1, h, t);
    check(h == 0, "R3 entry beyond count ignored", h, 0);
  endtask

  task automatic t_same_cycle();
    logic h; logic [31:0] t; logic [7:0] g;
    lk_valid = 1; lk_pc = 32'h3008; lk_tid = 0; lk_path_tgt = {32'h0, 32'h10}; lk_path_cnt = 1;
    upd_valid = 1; upd_pc = 32'h3008; upd_tid = 0; upd_target = 32'h88880000;
    upd_path_tgt = {32'h0, 32'h10}; upd_path_cnt = 1;
    tick(); lk_valid = 0; upd_valid = 0;
    check(res_hit && res_target == 32'h66660000, "R13 lookup sees old target", res_target, 32'h66660000);
    do_lookup(32'h3008, 0, {32'h0, 32'h10}, 2'd1, h, t);
    check(h && t == 32'h88880000, "R13 next lookup sees new", t, 32'h88880000);
    lk_valid = 1; lk_pc = 32'h2004; lk_tid = 0; lk_path_tgt = 0; lk_path_cnt = 0;
    dir_valid = 1; dir_tid = 0; dir_taken = 1;
    tick(); lk_valid = 0; dir_valid = 0;
    check(res_hit && res_target == 32'h55550000, "R13 lookup uses old history", res_target, 32'h55550000);
    read_ghr(0, g);
    check(g == 8'h01, "R9 history updated after same-cycle lookup", g, 1);
    do_squash(0, 8'h00);
  endtask

  task automatic t_backpressure();
    res_ready = 0;
    lk_valid = 1; lk_pc = 32'h1100; lk_tid = 0; lk_path_tgt = 0; lk_path_cnt = 0;
    tick();
    check(res_valid && res_target == 32'h44440000, "R12 first result", res_target, 32'h44440000);
    lk_pc = 32'h2004;
    tick();
    check(lk_ready == 0, "R12 ready low while stalled", lk_ready, 0);
    tick();
    check(res_valid && res_target == 32'h44440000, "R12 result held", res_target, 32'h44440000);
    res_ready = 1;
    #1;
    check(lk_ready == 1, "R12 ready with consumer", lk_ready, 1);
    tick(); lk_valid = 0;
    check(res_valid && res_target == 32'h55550000, "R12 next accepted", res_target, 32'h55550000);
    tick();
    check(res_valid == 0, "R12 drains", res_valid, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_hit_miss();
    t_fill();
    t_replace();
    t_history();
    t_threads();
    t_path();
    t_same_cycle();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule